// File: doc/BRIEF.md
# Boot Overlay Memory Decoder

This block sits between an 8-bit processor's 16-bit address bus and two memories: a small boot ROM and a RAM. After reset, an internal boot flag makes the top address bit look high on every access. Whatever address the processor issues, the ROM answers. This lets execution begin in ROM even though the processor starts fetching at address zero.

Firmware leaves this overlay by running an input instruction that uses the boot port code (1). From then on, low addresses reach RAM and high addresses reach ROM, until the next reset.

The block registers the chip selects, the memory addresses and the RAM write enable on the clock edge that follows the request. It returns the selected memory's read data to the processor using that same registered select. The contents of the memories and the processor's bus cycle timing are outside this block.

Top module: `boot_overlay_dec`

## Requirements
- R1: While `rst` is high, and in the cycle that follows the edge where it was high, `rom_cs`, `ram_cs` and `ram_we` are 0. Reset sets the boot flag.
- R2: While the boot flag is set, any access (`cpu_rd` or `cpu_wr` high) selects ROM one clock edge later, whatever `cpu_addr[15]` is.
- R3: An edge where `io_in_stb` is high and `io_port` equals 1 clears the boot flag. The access presented in that same cycle is still mapped with the flag set.
- R4: An input strobe with any `io_port` value other than 1 leaves the boot flag set.
- R5: Once cleared, the boot flag stays clear until the next reset, including through further strobes on port 1.
- R6: With the flag clear, an access with `cpu_addr[15]`=1 selects ROM and one with `cpu_addr[15]`=0 selects RAM.
- R7: `rom_addr` is the registered `cpu_addr[8:0]`, so the ROM mirrors every 512 bytes. `ram_addr` is the registered `cpu_addr[11:0]`, so the RAM mirrors every 4 kB below 0x8000.
- R8: `ram_we` rises one edge after a write that selects RAM. A write that selects ROM leaves `ram_we` at 0.
- R9: A cycle with neither `cpu_rd` nor `cpu_wr` leaves both selects at 0 after the next edge.
- R10: `cpu_rdata` equals `rom_rdata` while `rom_cs` is 1, `ram_rdata` while `ram_cs` is 1, and 0 when neither is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| io_in_stb | input | 1 | Input-instruction strobe |
| io_port | input | 3 | Port code of the input instruction |
| rom_rdata | input | 8 | ROM read data |
| ram_rdata | input | 8 | RAM read data |
| rom_cs | output | 1 | Registered ROM select |
| rom_addr | output | 9 | Registered ROM address |
| ram_cs | output | 1 | Registered RAM select |
| ram_addr | output | 12 | Registered RAM address |
| ram_we | output | 1 | Registered RAM write enable |
| cpu_rdata | output | 8 | Read data returned to the processor |

## Verification
The assertions assume the processor never raises `cpu_rd` and `cpu_wr` in the same cycle. They also assume that reset is held high from time zero until the first edges have passed. The bench drives one clean request per cycle with exactly one or none of the two strobes. It asserts reset from the start and changes inputs only on falling edges. Port strobes are applied both alongside accesses and in isolation, so the flag transition is seen mid-stream.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_RAM  = 2'd2
  } mem_sel_e;
endpackage

// File: rtl/boot_flag.sv
module boot_flag #(
  parameter int PORT_W    = 3,
  parameter int BOOT_PORT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_in_stb,
  input  logic [PORT_W-1:0] io_port,
  output logic              boot_q
);
  localparam logic [PORT_W-1:0] BootCode = PORT_W'(BOOT_PORT);

  logic clear_hit;
  assign clear_hit = io_in_stb && (io_port == BootCode);

  always_ff @(posedge clk) begin
    if (rst)            boot_q <= 1'b1;
    else if (clear_hit) boot_q <= 1'b0;
  end

  // R3
  boot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (io_in_stb && io_port == BootCode) |=> !boot_q);

  // R4
  boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (boot_q && !(io_in_stb && io_port == BootCode)) |=> boot_q);

  // R5
  boot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !boot_q |=> !boot_q);
endmodule

// File: rtl/addr_map.sv
module addr_map
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 9,
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output mem_sel_e          sel_q,
  output logic [ROM_AW-1:0] rom_addr_q,
  output logic [RAM_AW-1:0] ram_addr_q,
  output logic              ram_we_q
);
  localparam int TOP = ADDR_W - 1;

  logic     hi_region;
  logic     access;
  mem_sel_e sel_d;
  logic     unused_mid;

  assign hi_region  = cpu_addr[TOP] | boot;
  assign access     = cpu_rd | cpu_wr;
  assign unused_mid = ^cpu_addr[TOP-1:RAM_AW];

  always_comb begin
    sel_d = SEL_NONE;
    if (access) sel_d = hi_region ? SEL_ROM : SEL_RAM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= SEL_NONE;
      rom_addr_q <= '0;
      ram_addr_q <= '0;
      ram_we_q   <= 1'b0;
    end else begin
      sel_q      <= sel_d;
      rom_addr_q <= cpu_addr[ROM_AW-1:0];
      ram_addr_q <= cpu_addr[RAM_AW-1:0];
      ram_we_q   <= cpu_wr && (sel_d == SEL_RAM);
    end
  end

  // R2
  boot_rom_chk: assert property (@(posedge clk) disable iff (rst)
    (boot && (cpu_rd || cpu_wr)) |=> sel_q == SEL_ROM);

  // R8
  rom_write_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we_q |-> sel_q == SEL_RAM);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd || cpu_wr) |=> sel_q == SEL_NONE);
endmodule

// File: rtl/rdata_mux.sv
module rdata_mux
  import boot_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  mem_sel_e          sel,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  always_comb begin
    unique case (sel)
      SEL_ROM: cpu_rdata = rom_rdata;
      SEL_RAM: cpu_rdata = ram_rdata;
      default: cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/boot_overlay_dec.sv
module boot_overlay_dec
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ROM_AW    = 9,
  parameter int RAM_AW    = 12,
  parameter int PORT_W    = 3,
  parameter int BOOT_PORT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              io_in_stb,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_cs,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic     boot;
  mem_sel_e sel;

  boot_flag #(.PORT_W(PORT_W), .BOOT_PORT(BOOT_PORT)) u_flag (
    .clk(clk), .rst(rst), .io_in_stb(io_in_stb), .io_port(io_port),
    .boot_q(boot)
  );

  addr_map #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_map (
    .clk(clk), .rst(rst), .boot(boot), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .sel_q(sel),
    .rom_addr_q(rom_addr), .ram_addr_q(ram_addr), .ram_we_q(ram_we)
  );

  rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .sel(sel), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .cpu_rdata(cpu_rdata)
  );

  assign rom_cs = (sel == SEL_ROM);
  assign ram_cs = (sel == SEL_RAM);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!rom_cs && !ram_cs && !ram_we));

  // R6
  select_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rom_cs && ram_cs));

  // R6
  low_after_boot_chk: assert property (@(posedge clk) disable iff (rst)
    (!boot && cpu_rd && !cpu_addr[ADDR_W-1]) |=> ram_cs);
endmodule

// File: tb/boot_overlay_dec_bench.sv
module boot_overlay_dec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, io_in_stb = 1'b0;
  logic [2:0]  io_port = '0;
  logic [7:0]  rom_rdata = 8'hA5, ram_rdata = 8'h3C;
  logic        rom_cs, ram_cs, ram_we;
  logic [8:0]  rom_addr;
  logic [11:0] ram_addr;
  logic [7:0]  cpu_rdata;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  boot_overlay_dec u_boot_overlay_dec (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .io_in_stb(io_in_stb), .io_port(io_port),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_cs(rom_cs),
    .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_addr(ram_addr),
    .ram_we(ram_we), .cpu_rdata(cpu_rdata)
  );

  // {rd, wr, stb, port[2:0], addr[15:0], exp_rom, exp_ram, exp_we, exp_addr[11:0]}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,3'd0,16'h0000,1'b1,1'b0,1'b0,12'h000}, // R2 boot fetch
    {1'b1,1'b0,1'b0,3'd0,16'h1234,1'b1,1'b0,1'b0,12'h034}, // R2 R7
    {1'b0,1'b1,1'b0,3'd0,16'h0010,1'b1,1'b0,1'b0,12'h010}, // R8 write in boot
    {1'b1,1'b0,1'b1,3'd2,16'h0005,1'b1,1'b0,1'b0,12'h005}, // R4 port 2
    {1'b1,1'b0,1'b0,3'd0,16'h0005,1'b1,1'b0,1'b0,12'h005}, // R4 still ROM
    {1'b0,1'b0,1'b0,3'd0,16'h0099,1'b0,1'b0,1'b0,12'h000}, // R9 idle
    {1'b1,1'b0,1'b1,3'd1,16'h0007,1'b1,1'b0,1'b0,12'h007}, // R3 same cycle
    {1'b1,1'b0,1'b0,3'd0,16'h0007,1'b0,1'b1,1'b0,12'h007}, // R3 R6 RAM now
    {1'b0,1'b1,1'b0,3'd0,16'h0ABC,1'b0,1'b1,1'b1,12'hABC}, // R8 RAM write
    {1'b0,1'b1,1'b0,3'd0,16'h8ABC,1'b1,1'b0,1'b0,12'h0BC}, // R8 ROM write
    {1'b1,1'b0,1'b0,3'd0,16'hFFFF,1'b1,1'b0,1'b0,12'h1FF}, // R6 R7 ROM mirror
    {1'b1,1'b0,1'b0,3'd0,16'h7FFF,1'b0,1'b1,1'b0,12'hFFF}, // R7 RAM mirror
    {1'b1,1'b0,1'b1,3'd1,16'h0100,1'b0,1'b1,1'b0,12'h100}, // R5 re-strobe
    {1'b0,1'b0,1'b0,3'd0,16'h0000,1'b0,1'b0,1'b0,12'h000}  // R9 idle
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit rd, input bit wr, input bit stb,
                       input logic [2:0] port, input logic [15:0] a);
    cpu_rd = rd; cpu_wr = wr; io_in_stb = stb; io_port = port; cpu_addr = a;
  endtask

  task automatic check_out(input bit er, input bit em, input bit ew,
                           input logic [11:0] ea, input string tag);
    logic [7:0] ed;
    chk(rom_cs == er, {tag, " rom_cs"}, rom_cs, er);
    chk(ram_cs == em, {tag, " ram_cs"}, ram_cs, em);
    chk(ram_we == ew, {tag, " ram_we"}, ram_we, ew);
    if (er) chk(rom_addr == ea[8:0], {tag, " rom_addr"}, rom_addr, ea[8:0]);
    if (em) chk(ram_addr == ea, {tag, " ram_addr"}, ram_addr, ea);
    ed = er ? rom_rdata : (em ? ram_rdata : 8'h00);
    chk(cpu_rdata == ed, {tag, " R10 cpu_rdata"}, cpu_rdata, ed);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(1'b0, 1'b0, 1'b0, 12'h000, "R1 reset");
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:31], VEC[i][30:15]);
      @(negedge clk);
      check_out(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:0],
                $sformatf("vec%0d", i));
    end
    // R1: reset restores the boot flag after it was cleared
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 3'd0, 16'h0003);
    @(negedge clk);
    check_out(1'b0, 1'b0, 1'b0, 12'h000, "R1 reset again");
    rst = 1'b0;
    @(negedge clk);
    check_out(1'b1, 1'b0, 1'b0, 12'h003, "R1 flag reset");
    // R4: isolated strobes on ports 0 and 7 do not clear
    drive(1'b0, 1'b0, 1'b1, 3'd0, 16'h0000);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 3'd7, 16'h0000);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 3'd0, 16'h0042);
    @(negedge clk);
    check_out(1'b1, 1'b0, 1'b0, 12'h042, "R4 ports 0/7");
    // R10: mux follows changing ROM data
    rom_rdata = 8'h5A;
    #1;
    chk(cpu_rdata == 8'h5A, "R10 rom data change", cpu_rdata, 8'h5A);
    // R3: isolated port-1 strobe then RAM access
    drive(1'b0, 1'b0, 1'b1, 3'd1, 16'h0000);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 3'd0, 16'h0042);
    ram_rdata = 8'hC3;
    @(negedge clk);
    check_out(1'b0, 1'b1, 1'b0, 12'h042, "R3 isolated clear");
    drive(1'b0, 1'b0, 1'b0, 3'd0, 16'h0000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule